// File: doc/BRIEF.md
# Raw-12 Video Line Packetizer

This block converts a stream of 12-bit raw pixels into the byte sequence of a camera serial link for a single virtual channel. Each frame opens with a four-byte synchronisation packet that carries a frame number. Every video line then goes out as one long packet: a four-byte header with a byte count and a header check byte, the pixel payload packed two pixels to three bytes, and a two-byte CRC. A closing four-byte synchronisation packet ends the frame. Between packets the output stays silent for a programmable number of cycles and raises a gap flag, which stands in for the link's low-power state.

The pixel side is a valid/ready interface with a frame-end marker. The line length comes from configuration, so a line ends when the configured pixel count has been taken. The byte side is a registered valid/ready stream with a separate gap flag. The virtual channel, line length and gap length are captured when a frame starts and stay fixed until the frame is over.

Top module: `vid_pkt_framer`

## Requirements
- R1: After reset `out_valid`, `out_gap` and `pix_ready` are low, and they stay low while no pixel is offered. The first frame after reset carries frame number 1.
- R2: A frame starts when a pixel is offered while the block is idle. Its packets go out in this order: start packet, a gap, then each line's long packet followed by a gap, then the end packet followed by a gap. After that the block is idle.
- R3: The first byte of every packet is `{vc[1:0], type[5:0]}`. The type is 0x00 for frame start, 0x01 for frame end and 0x2C for a raw-12 line.
- R4: In both short packets, bytes 1 and 2 hold the 16-bit frame number, least significant byte first. The start and end packets of one frame carry the same number, and the number goes up by one for each frame.
- R5: In a line header, bytes 1 and 2 hold the payload byte count (3 × pixel pairs), least significant byte first. Byte 3 of every header is a check byte over D = {byte2, byte1, byte0}, where byte0 bit 0 is D0. Its bits 7:6 are zero. Bit k for k = 0 to 5 is the XOR of the bits of D selected by these masks: 0xF12CB7, 0xF2555B, 0x749A6D, 0xB8E38E, 0xDF03F0, 0xEFFC00.
- R6: Each pixel pair p0, p1 goes out as three bytes: p0[11:4], then p1[11:4], then {p1[3:0], p0[3:0]}.
- R7: The two footer bytes are a CRC-16 over the payload bytes only, least significant byte first. The CRC uses seed 0xFFFF, each byte is taken LSB first, and the reflected polynomial 0x8408 is applied (x^16+x^12+x^5+1) with no final inversion.
- R8: Every gap lasts exactly G cycles with `out_gap` high and `out_valid` low, where G is the captured gap setting. A setting of 0 counts as 1.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold, and no pixel is accepted.
- R10: Changes on `cfg_vc`, `cfg_line_pix` and `cfg_gap` after a frame has started have no effect on that frame.
- R11: The line length is rounded down to an even count. A count below 2 is treated as 2. `pix_eof` on any pixel of a line makes that line the last of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_vc | input | 2 | Virtual channel number |
| cfg_line_pix | input | LEN_W | Pixels per line |
| cfg_gap | input | GAP_W | Gap length in cycles |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Pixel taken this cycle |
| pix_data | input | 12 | Raw pixel value |
| pix_eof | input | 1 | Pixel belongs to the last line of the frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts byte |
| out_data | output | 8 | Output byte |
| out_gap | output | 1 | Inter-packet gap in progress |

## Verification
Frames are built with several combinations of channel, line length and gap length, and each received byte is compared with a stream computed from the requirements, including the gap count before it. A steady downstream and a pseudo-random ready pattern are both used, so holding on back-pressure can be told apart from data corruption. Pixel bubbles test that payload order and CRC do not depend on input timing. A frame that changes its configuration while running, and frames with an odd line length, a zero gap setting and a line length below 2, exercise capture and clamping. The gap flag is counted after the end packet, which covers the tail of the frame order.

// File: rtl/vpf_pkg.sv
package vpf_pkg;

  localparam int PIX_W  = 12;
  localparam int BYTE_W = 8;
  localparam int FCNT_W = 16;
  localparam int ECC_N  = 6;

  localparam logic [5:0] DT_FSTART = 6'h00;
  localparam logic [5:0] DT_FEND   = 6'h01;
  localparam logic [5:0] DT_RAW12  = 6'h2C;

  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_PAY, ST_FTR, ST_GAP} vpf_state_e;
  typedef enum logic [1:0] {PK_FS, PK_LINE, PK_FE} vpf_kind_e;

  // Parity coverage of each header check bit over the 24 header data bits
  function automatic logic [23:0] ecc_mask(input int k);
    case (k)
      0:       return 24'hF12CB7;
      1:       return 24'hF2555B;
      2:       return 24'h749A6D;
      3:       return 24'hB8E38E;
      4:       return 24'hDF03F0;
      default: return 24'hEFFC00;
    endcase
  endfunction

  // One byte of the reflected CRC-16, LSB of the byte first
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

endpackage

// File: rtl/vpf_hdr_ecc.sv
module vpf_hdr_ecc
  import vpf_pkg::*;
(
  input  logic [23:0] hdr,
  output logic [7:0]  ecc
);

  for (genvar k = 0; k < ECC_N; k++) begin : g_par
    assign ecc[k] = ^(hdr & ecc_mask(k));
  end
  assign ecc[7:ECC_N] = '0;

endmodule

// File: rtl/vpf_crc16.sv
module vpf_crc16
  import vpf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              en,
  input  logic [BYTE_W-1:0] din,
  output logic [15:0]       crc
);

  always_ff @(posedge clk) begin
    if (rst || init) crc <= 16'hFFFF;
    else if (en)     crc <= crc16_step(crc, din);
  end

  // R7
  crc_seed_chk: assert property (@(posedge clk) disable iff (rst)
    init |=> (crc == 16'hFFFF));

endmodule

// File: rtl/vpf_pair_pack.sv
module vpf_pair_pack
  import vpf_pkg::*;
#(
  parameter int LO_W = PIX_W - BYTE_W
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              take0,
  input  logic              take1,
  input  logic [LO_W-1:0]   lo_in,
  output logic [2*LO_W-1:0] tail
);

  logic [LO_W-1:0] lo0, lo1;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo0 <= '0;
      lo1 <= '0;
    end else begin
      if (take0) lo0 <= lo_in;
      if (take1) lo1 <= lo_in;
    end
  end

  assign tail = {lo1, lo0};

  // R6
  pack_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(take0 && take1));

endmodule

// File: rtl/vid_pkt_framer.sv
module vid_pkt_framer
  import vpf_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int GAP_W = 8
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_vc,
  input  logic [LEN_W-1:0]  cfg_line_pix,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              pix_eof,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_gap
);

  localparam int LO_W = PIX_W - BYTE_W;

  vpf_state_e        state;
  vpf_kind_e         kind;
  logic [1:0]        bidx;
  logic [1:0]        phase;
  logic [LEN_W-1:0]  pair_cnt;
  logic [LEN_W-1:0]  pairs_l;
  logic [LEN_W-1:0]  pairs_cfg;
  logic [1:0]        vc_l;
  logic [GAP_W-1:0]  gap_l;
  logic [GAP_W-1:0]  gap_cnt;
  logic [FCNT_W-1:0] fcnt;
  logic              last_line;

  logic              adv;
  logic [5:0]        dtype;
  logic [7:0]        di;
  logic [15:0]       wc;
  logic [15:0]       field;
  logic [7:0]        ecc;
  logic [BYTE_W-1:0] hdr_byte;
  logic [BYTE_W-1:0] tail;
  logic [BYTE_W-1:0] crc_din;
  logic [15:0]       crc;
  logic              crc_init;
  logic              crc_en;
  logic              take0;
  logic              take1;

  // Output register advances when empty or drained
  assign adv       = !out_valid || out_ready;
  assign pairs_cfg = cfg_line_pix >> 1;

  always_comb begin
    case (kind)
      PK_FS:   dtype = DT_FSTART;
      PK_FE:   dtype = DT_FEND;
      default: dtype = DT_RAW12;
    endcase
  end

  assign di    = {vc_l, dtype};
  assign wc    = 16'({pairs_l, 1'b0}) + 16'(pairs_l);
  assign field = (kind == PK_LINE) ? wc : fcnt;

  vpf_hdr_ecc u_ecc (
    .hdr ({field[15:8], field[7:0], di}),
    .ecc (ecc)
  );

  always_comb begin
    case (bidx)
      2'd0:    hdr_byte = di;
      2'd1:    hdr_byte = field[7:0];
      2'd2:    hdr_byte = field[15:8];
      default: hdr_byte = ecc;
    endcase
  end

  // Pixel side and payload side strobes
  assign pix_ready = (state == ST_PAY) && (phase != 2'd2) && adv;
  assign take0     = pix_ready && pix_valid && (phase == 2'd0);
  assign take1     = pix_ready && pix_valid && (phase == 2'd1);
  assign crc_init  = adv && (state == ST_HDR) && (bidx == 2'd0);
  assign crc_en    = adv && (state == ST_PAY) && ((phase == 2'd2) || pix_valid);
  assign crc_din   = (phase == 2'd2) ? tail : pix_data[PIX_W-1:LO_W];

  vpf_pair_pack #(.LO_W(LO_W)) u_pack (
    .clk   (clk),
    .rst   (rst),
    .take0 (take0),
    .take1 (take1),
    .lo_in (pix_data[LO_W-1:0]),
    .tail  (tail)
  );

  vpf_crc16 u_crc (
    .clk  (clk),
    .rst  (rst),
    .init (crc_init),
    .en   (crc_en),
    .din  (crc_din),
    .crc  (crc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      kind      <= PK_FS;
      bidx      <= '0;
      phase     <= '0;
      pair_cnt  <= '0;
      pairs_l   <= LEN_W'(1);
      vc_l      <= '0;
      gap_l     <= GAP_W'(1);
      gap_cnt   <= '0;
      fcnt      <= FCNT_W'(1);
      last_line <= 1'b0;
      out_valid <= 1'b0;
      out_gap   <= 1'b0;
      out_data  <= '0;
    end else if (adv) begin
      case (state)
        ST_IDLE: begin
          out_valid <= 1'b0;
          out_gap   <= 1'b0;
          if (pix_valid) begin
            vc_l    <= cfg_vc;
            pairs_l <= (pairs_cfg == '0) ? LEN_W'(1) : pairs_cfg;
            gap_l   <= (cfg_gap == '0) ? GAP_W'(1) : cfg_gap;
            kind    <= PK_FS;
            bidx    <= '0;
            state   <= ST_HDR;
          end
        end
        ST_HDR: begin
          out_valid <= 1'b1;
          out_gap   <= 1'b0;
          out_data  <= hdr_byte;
          bidx      <= bidx + 2'd1;
          if (bidx == 2'd0 && kind == PK_LINE) last_line <= 1'b0;
          if (bidx == 2'd3) begin
            if (kind == PK_LINE) begin
              state    <= ST_PAY;
              phase    <= '0;
              pair_cnt <= '0;
            end else begin
              state   <= ST_GAP;
              gap_cnt <= '0;
            end
          end
        end
        ST_PAY: begin
          out_gap <= 1'b0;
          if (phase == 2'd2) begin
            out_valid <= 1'b1;
            out_data  <= tail;
            phase     <= '0;
            pair_cnt  <= pair_cnt + 1'b1;
            if (pair_cnt == pairs_l - 1'b1) begin
              state <= ST_FTR;
              bidx  <= '0;
            end
          end else if (pix_valid) begin
            out_valid <= 1'b1;
            out_data  <= pix_data[PIX_W-1:LO_W];
            phase     <= phase + 2'd1;
            if (pix_eof) last_line <= 1'b1;
          end else begin
            out_valid <= 1'b0;
          end
        end
        ST_FTR: begin
          out_valid <= 1'b1;
          out_gap   <= 1'b0;
          out_data  <= (bidx == 2'd0) ? crc[7:0] : crc[15:8];
          bidx      <= bidx + 2'd1;
          if (bidx == 2'd1) begin
            state   <= ST_GAP;
            gap_cnt <= '0;
          end
        end
        ST_GAP: begin
          out_valid <= 1'b0;
          out_gap   <= 1'b1;
          gap_cnt   <= gap_cnt + 1'b1;
          if (gap_cnt == gap_l - 1'b1) begin
            bidx <= '0;
            case (kind)
              PK_FS: begin
                kind  <= PK_LINE;
                state <= ST_HDR;
              end
              PK_LINE: begin
                kind  <= last_line ? PK_FE : PK_LINE;
                state <= ST_HDR;
              end
              default: begin
                state <= ST_IDLE;
                fcnt  <= fcnt + 1'b1;
              end
            endcase
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker-only run length of the gap flag
  logic [GAP_W:0] gap_run;
  always_ff @(posedge clk) begin
    if (rst)          gap_run <= '0;
    else if (out_gap) gap_run <= gap_run + 1'b1;
    else              gap_run <= '0;
  end

  // R8
  gap_excl_chk: assert property (@(posedge clk) disable iff (rst)
    out_gap |-> !out_valid);

  // R8
  gap_len_chk: assert property (@(posedge clk) disable iff (rst)
    out_gap |-> (gap_run < {1'b0, gap_l}));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9
  no_take_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !pix_ready);

  // R6
  pix_first_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && pix_ready) |=> (out_valid && out_data == $past(pix_data[PIX_W-1:LO_W])));

endmodule

// File: tb/test_vid_pkt_framer.sv
module test_vid_pkt_framer;

  localparam int LEN_W = 16;
  localparam int GAP_W = 8;
  localparam int MAXB  = 512;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       cfg_vc = '0;
  logic [LEN_W-1:0] cfg_line_pix = '0;
  logic [GAP_W-1:0] cfg_gap = '0;
  logic             pix_valid = 1'b0;
  logic             pix_ready;
  logic [11:0]      pix_data = '0;
  logic             pix_eof = 1'b0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [7:0]       out_data;
  logic             out_gap;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  vid_pkt_framer #(.LEN_W(LEN_W), .GAP_W(GAP_W)) i_vid_pkt_framer (
    .clk(clk), .rst(rst), .cfg_vc(cfg_vc), .cfg_line_pix(cfg_line_pix), .cfg_gap(cfg_gap),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data), .pix_eof(pix_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_gap(out_gap)
  );

  // Downstream ready pattern
  logic       bp_mode = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = bp_mode ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  // Output monitor
  logic [7:0] rx_data [MAXB];
  int         rx_gap  [MAXB];
  int         rx_n = 0;
  int         gap_run = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (out_gap) gap_run++;
      if (out_valid && out_ready && rx_n < MAXB) begin
        rx_data[rx_n] = out_data;
        rx_gap[rx_n]  = gap_run;
        gap_run = 0;
        rx_n++;
      end
    end
  end

  // Expected stream
  logic [7:0] ex_data [MAXB];
  int         ex_gap  [MAXB];
  string      ex_req  [MAXB];
  int         ex_n = 0;
  int         fc_exp = 1;

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] ecc_ref(input logic [23:0] d);
    logic [23:0] m [6];
    logic [7:0]  e;
    m[0] = 24'hF12CB7; m[1] = 24'hF2555B; m[2] = 24'h749A6D;
    m[3] = 24'hB8E38E; m[4] = 24'hDF03F0; m[5] = 24'hEFFC00;
    e = '0;
    for (int k = 0; k < 6; k++) e[k] = ^(d & m[k]);
    return e;
  endfunction

  function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ 16'h8408;
      else             r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [11:0] pixval(input int f, input int l, input int i);
    return 12'((f * 911 + l * 257 + i * 1013) ^ (i << 7) ^ (l << 3));
  endfunction

  task automatic push(input logic [7:0] b, input int g, input string req);
    ex_data[ex_n] = b;
    ex_gap[ex_n]  = g;
    ex_req[ex_n]  = req;
    ex_n++;
  endtask

  task automatic push_hdr(input logic [7:0] di, input logic [15:0] fld, input int g, input string freq);
    push(di, g, "R3");
    push(fld[7:0], 0, freq);
    push(fld[15:8], 0, freq);
    push(ecc_ref({fld[15:8], fld[7:0], di}), 0, "R5");
  endtask

  task automatic build(input logic [1:0] vc, input int lines, input int npix, input int gap);
    logic [15:0] crc;
    logic [11:0] p0, p1;
    ex_n = 0;
    push_hdr({vc, 6'h00}, 16'(fc_exp), 0, "R4");
    for (int l = 0; l < lines; l++) begin
      push_hdr({vc, 6'h2C}, 16'(npix / 2 * 3), gap, "R5");
      crc = 16'hFFFF;
      for (int i = 0; i < npix; i += 2) begin
        p0 = pixval(fc_exp, l, i);
        p1 = pixval(fc_exp, l, i + 1);
        push(p0[11:4], 0, "R6");             crc = crc_ref(crc, p0[11:4]);
        push(p1[11:4], 0, "R6");             crc = crc_ref(crc, p1[11:4]);
        push({p1[3:0], p0[3:0]}, 0, "R6");   crc = crc_ref(crc, {p1[3:0], p0[3:0]});
      end
      push(crc[7:0], 0, "R7");
      push(crc[15:8], 0, "R7");
    end
    push_hdr({vc, 6'h01}, 16'(fc_exp), gap, "R4");
  endtask

  // One frame: configure, drive pixels, compare every byte and gap count
  task automatic run_frame(input string req, input logic [1:0] vc, input int cfg_len, input int npix,
                           input int cfg_g, input int gap, input int lines, input bit bp,
                           input bit bubble, input bit chg);
    int wait_cyc;
    cfg_vc = vc; cfg_line_pix = LEN_W'(cfg_len); cfg_gap = GAP_W'(cfg_g);
    bp_mode = bp;
    rx_n = 0; gap_run = 0;
    build(vc, lines, npix, gap);
    for (int l = 0; l < lines; l++) begin
      for (int i = 0; i < npix; i++) begin
        pix_data  = pixval(fc_exp, l, i);
        pix_eof   = (l == lines - 1) && (i == npix - 1);
        pix_valid = 1'b1;
        do @(negedge clk); while (!pix_ready);
        @(posedge clk); #1;
        pix_valid = 1'b0;
        pix_eof   = 1'b0;
        if (chg && l == 0 && i == 0) begin
          // R10: reconfigure mid-frame
          cfg_vc = ~vc; cfg_line_pix = LEN_W'(cfg_len + 6); cfg_gap = GAP_W'(cfg_g + 5);
        end
        if (bubble && (i % 3 == 1)) repeat (2) @(posedge clk);
        #0;
      end
    end
    wait_cyc = 0;
    while (rx_n < ex_n && wait_cyc < 5000) begin
      @(posedge clk);
      wait_cyc++;
    end
    repeat (gap + 12) @(posedge clk);
    #1;
    bp_mode = 1'b0;
    check(req, "byte count (R2)", rx_n, ex_n);
    for (int k = 0; k < ex_n && k < rx_n; k++) begin
      check(ex_req[k], $sformatf("%s byte %0d", req, k), rx_data[k], ex_data[k]);
      check("R8", $sformatf("%s gap before byte %0d", req, k), rx_gap[k], ex_gap[k]);
    end
    check("R2", $sformatf("%s gap after frame end", req), gap_run, gap);
    fc_exp++;
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R1", "out_valid idle", int'(out_valid), 0);
    check("R1", "out_gap idle", int'(out_gap), 0);
    check("R1", "pix_ready idle", int'(pix_ready), 0);
    @(posedge clk); #1;
  endtask

  task automatic test_basic();
    // R2 R3 R4 R5 R6 R7 R8: plain frame, steady downstream
    run_frame("basic", 2'd1, 4, 4, 2, 2, 2, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic test_backpressure();
    // R9: random downstream ready
    run_frame("R9 backpressure", 2'd2, 6, 6, 3, 3, 3, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic test_bubbles();
    // R6 R7: pixel bubbles must not change bytes or CRC
    run_frame("bubbles", 2'd3, 8, 8, 1, 1, 2, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic test_cfg_change();
    run_frame("R10 cfg change", 2'd0, 4, 4, 2, 2, 2, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic test_odd_zero();
    // R11: odd length rounds down, R8: zero gap setting means one cycle
    run_frame("R11 odd length", 2'd1, 5, 4, 0, 1, 2, 1'b1, 1'b0, 1'b0);
    // R11: length below two clamps to one pair
    run_frame("R11 short line", 2'd2, 1, 2, 4, 4, 1, 1'b0, 1'b0, 1'b0);
  endtask

  bit done = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_basic();
    test_backpressure();
    test_bubbles();
    test_cfg_change();
    test_odd_zero();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule